// File: doc/BRIEF.md
# Mode-Programmed Burst Column Generator

This block watches the DRAM command pins for a mode register write, checks the programmed settings and holds them: burst length, burst type and read latency. It then turns each burst start into the column address sequence that the burst walks. One column beat is produced per clock, because two data words move in each clock. Fixed-length bursts therefore take half as many clocks as their length. A full-page burst runs until a terminate input arrives.

The block sits between a memory controller's command scheduler and its address path. The scheduler issues the mode write and the burst starts. The generator refuses anything that breaks the programming rules: a write while any bank is open, a write during a burst, a command inside the two-clock settling window after a mode write, and reserved or conflicting field codes. An illegal setting raises a sticky flag, and the last legal setting stays in force.

Top module: `burst_colgen`

## Requirements
- R1: A mode write is taken at a rising clock edge when csN, rasN, casN and weN are all low and bankAddr[0] is 0. With bankAddr[0] = 1 the same command is aimed at the extended register and leaves every output unchanged.
- R2: The burst length code is addrBus[2:0]. 001 gives 2, 010 gives 4 and 011 gives 8, and burstLen reports these values. 111 gives full page, and burstLen then reports 256. Any other code sets illegalSet and keeps the previous setting.
- R3: addrBus[3] selects the burst type: 0 is sequential and 1 is interleave (interleave output = 1). Full page together with interleave is illegal: illegalSet is set and the previous setting is kept.
- R4: The read latency code is addrBus[6:4]. 011 gives 3, 100 gives 4 and 101 gives 5, and readLatency carries the latency as a number. Any other code is illegal and keeps the previous setting.
- R5: addrBus[7] (test mode), addrBus[8] (DLL reset request), addrBus[10:9] and bankAddr[1] must all be 0. If any of them is 1, the write is illegal and keeps the previous setting.
- R6: A mode write is ignored unless all four bankIdle bits are 1 and no burst is running. An ignored write changes neither the setting nor illegalSet.
- R7: A mode write taken at edge t starts a settling window, whether the write was legal or illegal. At edge t+1 both a further mode write and burstGo are ignored. At edge t+2 both are accepted again.
- R8: After reset the setting is burst length 2, sequential, latency 3. illegalSet and colValid are 0.
- R9: A fixed-length sequential burst started at edge t drives colValid high for exactly BL/2 clocks. Beat k (k = 0 .. BL/2-1), visible after edge t+k, is the start column with its low log2(BL) bits replaced by (start + 2k) mod BL. colValid is 0 after edge t+BL/2.
- R10: In interleave mode, beat k is the start column with its low log2(BL) bits XORed with 2k. The beat count is the same as in R9.
- R11: A full-page burst gives beat k = (start + 2k) mod 256 and runs until burstStop is high at an edge. After that edge colValid is 0. A full-page start on an odd column sets illegalSet and starts no burst.
- R12: burstGo is ignored when all bankIdle bits are 1, while a burst is running, or at an edge that carries a mode write command. burstStop has no effect on fixed-length bursts.
- R13: A legal, accepted mode write clears illegalSet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 2 | Bank address; bit 0 picks the extended register |
| addrBus | input | 11 | Address bus carrying the mode fields |
| bankIdle | input | 4 | One bit per bank, 1 = bank precharged |
| burstGo | input | 1 | Start a burst at this edge |
| startCol | input | 8 | First column of the burst |
| burstStop | input | 1 | Terminate a full-page burst |
| burstLen | output | 9 | Programmed burst length (2, 4, 8 or 256) |
| interleave | output | 1 | 1 = interleave ordering |
| readLatency | output | 3 | Programmed read latency in clocks |
| illegalSet | output | 1 | Sticky flag for a refused setting or an odd full-page start |
| colAddr | output | 8 | Column address of the current beat |
| colValid | output | 1 | colAddr holds a beat of a running burst |

## Verification
A wrong stored mode shows at once on burstLen, interleave and readLatency, one clock after the mode write. A wrong beat counter or a wrong ordering shows as a wrong colAddr on the very beat where it goes wrong, or as colValid falling one clock early or late. An error in the settling window or in the idle gating shows as a write or a start that took effect when it should have been dropped, and it appears one edge after the offending command. A wrong legality decode shows either as illegalSet rising with no cause or as a reserved code reaching the outputs.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic modeLoad;   // store the fields on addrBus
    logic flagSet;    // raise the sticky illegal flag
    logic flagClr;    // clear it
    logic burstLoad;  // capture start column, reset beat count
    logic beatStep;   // advance to the next beat
    logic burstEnd;   // running burst finishes at this edge
  } ctrlStrb_t;

  localparam logic [2:0] BL_CODE_FULL = 3'b111;
  localparam logic [2:0] BL_CODE_RST  = 3'b001;
  localparam logic [2:0] CL_CODE_RST  = 3'b011;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BANKS    = 4,
  parameter int MRD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [BANKS-1:0]  bankIdle,
  input  logic              burstGo,
  input  logic              startOdd,
  input  logic              burstStop,
  input  logic              curFull,
  input  logic              lastBeat,
  output ctrlStrb_t         strb,
  output logic              burstActive
);

  localparam int MRD_W = $clog2(MRD_CLKS) + 1;
  localparam logic [MRD_W-1:0] MRD_LOAD = MRD_W'(MRD_CLKS - 1);

  logic             activeQ;
  logic [MRD_W-1:0] mrdCnt;
  logic             mrdBusy;
  logic             allIdle;
  logic             modeCmd;
  logic             modeTry;
  logic             modeOk;
  logic             blOk;
  logic             clOk;
  logic             rsvOk;
  logic             goTry;
  logic             oddReject;

  assign allIdle = &bankIdle;
  assign mrdBusy = (mrdCnt != '0);
  assign modeCmd = !csN && !rasN && !casN && !weN && !bankAddr[0];
  assign modeTry = modeCmd && allIdle && !activeQ && !mrdBusy;

  // field legality
  always_comb begin
    blOk  = (addrBus[2:0] inside {3'b001, 3'b010, 3'b011}) ||
            ((addrBus[2:0] == BL_CODE_FULL) && !addrBus[3]);
    clOk  = addrBus[6:4] inside {3'b011, 3'b100, 3'b101};
    rsvOk = (addrBus[ADDR_W-1:7] == '0) && !bankAddr[1];
    modeOk = blOk && clOk && rsvOk;
  end

  assign goTry     = burstGo && !modeCmd && !mrdBusy && !allIdle && !activeQ;
  assign oddReject = goTry && curFull && startOdd;

  always_comb begin
    strb.modeLoad  = modeTry && modeOk;
    strb.flagClr   = modeTry && modeOk;
    strb.flagSet   = (modeTry && !modeOk) || oddReject;
    strb.burstLoad = goTry && !oddReject;
    strb.burstEnd  = activeQ && (curFull ? burstStop : lastBeat);
    strb.beatStep  = activeQ && !strb.burstEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      mrdCnt  <= '0;
    end else begin
      if (strb.burstLoad)     activeQ <= 1'b1;
      else if (strb.burstEnd) activeQ <= 1'b0;
      if (modeTry)            mrdCnt <= MRD_LOAD;
      else if (mrdBusy)       mrdCnt <= mrdCnt - 1'b1;
    end
  end

  assign burstActive = activeQ;

  AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    modeTry |=> !modeTry && !strb.burstLoad);                     // R7

  AST_START_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    strb.burstLoad |-> !allIdle && !burstActive);                  // R12

  AST_NO_MODE_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    burstActive |-> !strb.modeLoad);                               // R6

endmodule

// File: rtl/burst_path.sv
module burst_path
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [6:0]       modeBits,
  input  logic [COL_W-1:0] startCol,
  input  logic             burstActive,
  output logic [COL_W:0]   burstLen,
  output logic             interleave,
  output logic [2:0]       readLatency,
  output logic             illegalSet,
  output logic [COL_W-1:0] colAddr,
  output logic             curFull,
  output logic             lastBeat
);

  localparam int BEAT_W = COL_W - 1;

  logic [2:0]        blCodeQ;
  logic              ilvQ;
  logic [2:0]        clCodeQ;
  logic              illegalQ;
  logic [COL_W-1:0]  startQ;
  logic [BEAT_W-1:0] beatQ;
  logic [COL_W-1:0]  offset;
  logic [COL_W-1:0]  seqSum;
  logic [COL_W-1:0]  blkMask;
  logic [BEAT_W-1:0] halfM1;
  logic              useIlv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blCodeQ  <= BL_CODE_RST;
      ilvQ     <= 1'b0;
      clCodeQ  <= CL_CODE_RST;
      illegalQ <= 1'b0;
      startQ   <= '0;
      beatQ    <= '0;
    end else begin
      if (strb.modeLoad) begin
        blCodeQ <= modeBits[2:0];
        ilvQ    <= modeBits[3];
        clCodeQ <= modeBits[6:4];
      end
      if (strb.flagSet)      illegalQ <= 1'b1;
      else if (strb.flagClr) illegalQ <= 1'b0;
      if (strb.burstLoad) begin
        startQ <= startCol;
        beatQ  <= '0;
      end else if (strb.beatStep) begin
        beatQ  <= beatQ + 1'b1;
      end
    end
  end

  always_comb begin
    curFull  = (blCodeQ == BL_CODE_FULL);
    burstLen = curFull ? ((COL_W+1)'(1) << COL_W) : ((COL_W+1)'(1) << blCodeQ);
    blkMask  = COL_W'(burstLen - (COL_W+1)'(1));
    halfM1   = BEAT_W'((burstLen >> 1) - (COL_W+1)'(1));
    lastBeat = !curFull && (beatQ == halfM1);
    offset   = {beatQ, 1'b0};
    seqSum   = startQ + offset;
    useIlv   = ilvQ && !curFull;
  end

  // per column bit: outside the burst block keep the start, inside
  // either add (sequential) or XOR (interleave) the beat offset
  for (genvar b = 0; b < COL_W; b++) begin : gColBit
    assign colAddr[b] = !blkMask[b] ? startQ[b]
                      : (useIlv ? (startQ[b] ^ offset[b]) : seqSum[b]);
  end

  assign interleave  = ilvQ;
  assign readLatency = clCodeQ;
  assign illegalSet  = illegalQ;

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.modeLoad |=> $stable({blCodeQ, ilvQ, clCodeQ}));         // R2

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    clCodeQ inside {3'b011, 3'b100, 3'b101});                      // R4

  AST_NO_ILV_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !(ilvQ && curFull));                                           // R3

  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    burstActive && !curFull |-> beatQ <= halfM1);                  // R9

  AST_FULL_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstActive) && curFull |-> !colAddr[0]);                // R11

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int ADDR_W   = 11,
  parameter int BANKS    = 4,
  parameter int MRD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [BANKS-1:0]  bankIdle,
  input  logic              burstGo,
  input  logic [COL_W-1:0]  startCol,
  input  logic              burstStop,
  output logic [COL_W:0]    burstLen,
  output logic              interleave,
  output logic [2:0]        readLatency,
  output logic              illegalSet,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid
);

  ctrlStrb_t strb;
  logic      burstActive;
  logic      curFull;
  logic      lastBeat;

  burst_ctrl #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .MRD_CLKS(MRD_CLKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .addrBus(addrBus), .bankIdle(bankIdle),
    .burstGo(burstGo), .startOdd(startCol[0]), .burstStop(burstStop),
    .curFull(curFull), .lastBeat(lastBeat),
    .strb(strb), .burstActive(burstActive)
  );

  burst_path #(
    .COL_W(COL_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .modeBits(addrBus[6:0]), .startCol(startCol),
    .burstActive(burstActive),
    .burstLen(burstLen), .interleave(interleave),
    .readLatency(readLatency), .illegalSet(illegalSet),
    .colAddr(colAddr), .curFull(curFull), .lastBeat(lastBeat)
  );

  assign colValid = burstActive;

endmodule

// File: tb/tb_burst_colgen.sv
`timescale 1ns/1ps
module tb_burst_colgen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  bankAddr = '0;
  logic [10:0] addrBus = '0;
  logic [3:0]  bankIdle = 4'hF;
  logic        burstGo = 1'b0;
  logic [7:0]  startCol = '0;
  logic        burstStop = 1'b0;
  logic [8:0]  burstLen;
  logic        interleave;
  logic [2:0]  readLatency;
  logic        illegalSet;
  logic [7:0]  colAddr;
  logic        colValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  burst_colgen dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .addrBus(addrBus), .bankIdle(bankIdle),
    .burstGo(burstGo), .startCol(startCol), .burstStop(burstStop),
    .burstLen(burstLen), .interleave(interleave), .readLatency(readLatency),
    .illegalSet(illegalSet), .colAddr(colAddr), .colValid(colValid)
  );

  // mode vectors: address, bank, expected {len, ilv, latency, flag}
  localparam int NV = 14;
  localparam logic [10:0] V_ADDR [NV] = '{
    11'h032, 11'h04B, 11'h057, 11'h05F, 11'h030, 11'h021, 11'h041,
    11'h141, 11'h0C1, 11'h032, 11'h432, 11'h03A, 11'h034, 11'h063};
  localparam logic [1:0] V_BA [NV] = '{
    2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
    2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam logic [13:0] V_EXP [NV] = '{
    {9'd4,   1'b0, 3'd3, 1'b0}, {9'd8,   1'b1, 3'd4, 1'b0},
    {9'd256, 1'b0, 3'd5, 1'b0}, {9'd256, 1'b0, 3'd5, 1'b1},
    {9'd256, 1'b0, 3'd5, 1'b1}, {9'd256, 1'b0, 3'd5, 1'b1},
    {9'd2,   1'b0, 3'd4, 1'b0}, {9'd2,   1'b0, 3'd4, 1'b1},
    {9'd2,   1'b0, 3'd4, 1'b1}, {9'd2,   1'b0, 3'd4, 1'b1},
    {9'd2,   1'b0, 3'd4, 1'b1}, {9'd4,   1'b1, 3'd3, 1'b0},
    {9'd4,   1'b1, 3'd3, 1'b1}, {9'd4,   1'b1, 3'd3, 1'b1}};

  function automatic logic [13:0] snap();
    return {burstLen, interleave, readLatency, illegalSet};
  endfunction

  function automatic logic [7:0] expCol(input logic [7:0] s, input int k,
                                        input int bl, input bit ilv);
    logic [7:0] off, mask;
    off = 8'(2 * k);
    if (bl == 256) return s + off;
    mask = 8'(bl - 1);
    if (ilv) return s ^ (off & mask);
    return (s & ~mask) | ((s + off) & mask);
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic nop();
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic modeWr(input logic [10:0] a, input logic [1:0] ba);
    @(negedge clk);
    csN = 1'b0; rasN = 1'b0; casN = 1'b0; weN = 1'b0;
    addrBus = a; bankAddr = ba;
    tick();
    nop(); bankAddr = 2'd0;
  endtask

  task automatic runBurst(input string tag, input logic [7:0] s,
                          input int bl, input bit ilv);
    @(negedge clk);
    burstGo = 1'b1; startCol = s;
    tick();
    burstGo = 1'b0;
    for (int k = 0; k < bl / 2; k++) begin
      if (k > 0) tick();
      check(tag, {colValid, colAddr}, {1'b1, expCol(s, k, bl, ilv)});
    end
    tick();
    check(tag, colValid, 1'b0);
  endtask

  task automatic runFull(input logic [7:0] s, input int beats);
    @(negedge clk);
    burstGo = 1'b1; startCol = s;
    tick();
    burstGo = 1'b0;
    for (int k = 0; k < beats; k++) begin
      if (k > 0) tick();
      check("R11 full page beat", {colValid, colAddr},
            {1'b1, expCol(s, k, 256, 1'b0)});
    end
    @(negedge clk);
    burstStop = 1'b1;
    tick();
    burstStop = 1'b0;
    check("R11 stop ends full page", colValid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures",
               nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tick();
    check("R8 reset mode", snap(), {9'd2, 1'b0, 3'd3, 1'b0});
    check("R8 reset colValid", colValid, 1'b0);

    // table walk: R1 R2 R3 R4 R5 R13
    for (int i = 0; i < NV; i++) begin
      modeWr(V_ADDR[i], V_BA[i]);
      check("R2 R3 R4 R5 R13 mode vector", snap(), V_EXP[i]);
      tick();
    end

    // R1: extended register select leaves mode alone
    modeWr(11'h057, 2'd1);
    check("R1 extended write ignored", snap(), {9'd4, 1'b1, 3'd3, 1'b1});
    tick();

    // R6: open bank blocks the write, flag untouched
    bankIdle = 4'b1110;
    modeWr(11'h041, 2'd0);
    check("R6 write with open bank", snap(), {9'd4, 1'b1, 3'd3, 1'b1});
    bankIdle = 4'hF;
    tick();

    // R7: settling window
    modeWr(11'h032, 2'd0);
    check("R7 first write", snap(), {9'd4, 1'b0, 3'd3, 1'b0});
    modeWr(11'h04B, 2'd0);
    check("R7 write at t+1 dropped", snap(), {9'd4, 1'b0, 3'd3, 1'b0});
    modeWr(11'h04B, 2'd0);
    check("R7 write at t+2 taken", snap(), {9'd8, 1'b1, 3'd4, 1'b0});
    @(negedge clk);
    bankIdle = 4'b1110; burstGo = 1'b1; startCol = 8'h10;
    tick();
    burstGo = 1'b0;
    check("R7 start at t+1 dropped", colValid, 1'b0);
    bankIdle = 4'hF;
    tick();

    // R9 sequential
    modeWr(11'h032, 2'd0); tick(); bankIdle = 4'b1110;
    runBurst("R9 seq BL4", 8'h05, 4, 1'b0);
    runBurst("R9 seq BL4 wrap", 8'hFE, 4, 1'b0);
    bankIdle = 4'hF;
    modeWr(11'h033, 2'd0); tick(); bankIdle = 4'b1110;
    runBurst("R9 seq BL8", 8'h06, 8, 1'b0);
    bankIdle = 4'hF;
    modeWr(11'h031, 2'd0); tick(); bankIdle = 4'b1110;
    runBurst("R9 seq BL2", 8'h37, 2, 1'b0);
    bankIdle = 4'hF;

    // R10 interleave
    modeWr(11'h03B, 2'd0); tick(); bankIdle = 4'b1110;
    runBurst("R10 ilv BL8", 8'h06, 8, 1'b1);
    runBurst("R10 ilv BL8 odd", 8'h2D, 8, 1'b1);
    bankIdle = 4'hF;
    modeWr(11'h03A, 2'd0); tick(); bankIdle = 4'b1110;
    runBurst("R10 ilv BL4", 8'h13, 4, 1'b1);

    // R12: no start with all banks idle
    bankIdle = 4'hF;
    @(negedge clk); burstGo = 1'b1; startCol = 8'h20;
    tick();
    burstGo = 1'b0;
    check("R12 start with all idle dropped", colValid, 1'b0);

    // R12: restart and stop ignored in a fixed burst
    @(negedge clk); bankIdle = 4'b1110; burstGo = 1'b1; startCol = 8'h20;
    tick();
    check("R12 burst beat 0", {colValid, colAddr}, {1'b1, 8'h20});
    @(negedge clk); startCol = 8'h40; burstStop = 1'b1;
    tick();
    burstGo = 1'b0; burstStop = 1'b0;
    check("R12 restart and stop ignored", {colValid, colAddr}, {1'b1, 8'h22});
    tick();
    check("R12 fixed burst ends on count", colValid, 1'b0);

    // R6: mode write during a running burst is dropped
    @(negedge clk); burstGo = 1'b1; startCol = 8'h20;
    tick();
    burstGo = 1'b0;
    @(negedge clk);
    bankIdle = 4'hF;
    csN = 1'b0; rasN = 1'b0; casN = 1'b0; weN = 1'b0; addrBus = 11'h057;
    tick();
    nop();
    check("R6 burst continues", {colValid, colAddr}, {1'b1, 8'h22});
    tick();
    check("R6 write during burst dropped", snap(), {9'd4, 1'b1, 3'd3, 1'b0});

    // R11 full page
    modeWr(11'h037, 2'd0);
    check("R11 full page setting", snap(), {9'd256, 1'b0, 3'd3, 1'b0});
    tick(); bankIdle = 4'b1110;
    runFull(8'hFC, 4);
    runFull(8'h10, 132);
    @(negedge clk); burstGo = 1'b1; startCol = 8'h11;
    tick();
    burstGo = 1'b0;
    check("R11 odd full page start", {colValid, illegalSet}, {1'b0, 1'b1});
    tick();
    check("R11 odd start still idle", colValid, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks, nFails);
    $finish;
  end

endmodule